// File: doc/BRIEF.md
# GPU First-Level Data Cache Request Controller

This block decides, one access per cycle, what a first-level GPU data cache does with a load, store or atomic. It looks the block address up in a set-associative tag array held in the block, answers in the same cycle with HIT, MISS or RESERVATION_FAIL, and updates line state and true-LRU ages at the next clock edge. Every request it sends toward the next level goes into a bounded outgoing queue, which a consumer drains over a valid/ready pair.

The write policy depends on the kind of memory each access targets. A store to global memory that hits writes through and drops the line. A store to local memory that hits stays in the cache as dirty data. Store misses never allocate. A load miss reserves a victim way and sends a line fill. If the victim is dirty, a writeback follows the fill. A small table of outstanding misses lets later loads to a block that is already pending merge into its entry. A separate fill input completes a pending miss and makes its line usable.

No access is taken unless the queue can absorb the worst case it might produce. A refused access leaves every piece of state as it was.

Top module: `gpu_l1d_ctrl`

## Requirements
- R1: After reset every line is invalid, the outgoing queue is empty (`mqValid` low) and no miss is pending, so the first load to any block returns MISS.
- R2: A load that hits returns HIT (status code 0), pushes nothing and makes that way the most recently used.
- R3: A load miss is accepted only while the queue has at least two free slots; otherwise it returns RESERVATION_FAIL (code 2) and changes no state. An accepted allocating load miss returns MISS (code 1) and pushes a READ entry (type 0) carrying the block address (address bits above the 7-bit line offset) and size 128.
- R4: When an allocating load miss displaces a dirty line, a WRITEBACK entry (type 2) with the victim's block address and size 128 is pushed directly after the READ.
- R5: The victim is the first invalid way of the set if there is one. Otherwise it is the least recently used way among the valid and dirty ways, with ages updated by load hits, local store hits and fills.
- R6: A global store (`reqLocal`=0) that hits returns HIT, pushes a WRITE entry (type 1) with the block address and `reqSize`, and invalidates the line. It needs one free slot, else it returns RESERVATION_FAIL and the line stays valid.
- R7: A local store (`reqLocal`=1) that hits returns HIT, marks the line dirty, makes it most recently used and pushes nothing.
- R8: A store miss returns MISS and pushes a WRITE entry with `reqSize`, without allocating a line. With no free slot it returns RESERVATION_FAIL.
- R9: A global atomic load that hits marks the line dirty, so its later eviction produces a writeback.
- R10: A load miss to a block with a pending entry that holds fewer than MSHR_MAX_MERGE requests merges into it: it returns MISS and pushes nothing. At the limit it returns RESERVATION_FAIL.
- R11: A load miss with no pending entry for its block, and no free pending entry or no usable victim way, returns RESERVATION_FAIL.
- R12: A fill for a pending block makes the reserved line valid and most recently used, and frees its pending entry. Any access presented in the same cycle as a fill returns RESERVATION_FAIL.
- R13: Queue entries leave in the order they were accepted, one per cycle in which `mqValid` and `mqReady` are both high, and the queue never exceeds MQ_DEPTH entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | An access is presented this cycle |
| reqAddr | input | ADDR_W | Byte address of the access |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqAtomic | input | 1 | Load is an atomic read-modify-write |
| reqLocal | input | 1 | 1 = local memory, 0 = global memory |
| reqSize | input | log2(LINE_BYTES)+1 | Store size in bytes |
| respValid | output | 1 | Status is valid (follows reqValid) |
| respStatus | output | 2 | 0 HIT, 1 MISS, 2 RESERVATION_FAIL |
| fillValid | input | 1 | A line fill returns this cycle |
| fillBlockAddr | input | ADDR_W-log2(LINE_BYTES) | Block address of the fill |
| mqValid | output | 1 | Queue head is valid |
| mqReady | input | 1 | Consumer takes the head |
| mqType | output | 2 | 0 READ, 1 WRITE, 2 WRITEBACK |
| mqBlockAddr | output | ADDR_W-log2(LINE_BYTES) | Block address of the head entry |
| mqSize | output | log2(LINE_BYTES)+1 | Size in bytes of the head entry |

## Verification
The bench builds the block with two pending-miss entries, two requests per pending entry and a four-slot queue. The 16-set, 4-way array stays at its default size. With these values the merge limit, pending-table exhaustion and a full queue can each be reached within a handful of accesses. A long LRU replacement chain in one set also leaves a dirty line as the oldest, so its writeback and the ordering of queue entries behind it can be observed at the queue output.

// File: rtl/l1d_pkg.sv
package l1d_pkg;

  typedef enum logic [1:0] {
    ST_HIT     = 2'd0,
    ST_MISS    = 2'd1,
    ST_RESFAIL = 2'd2
  } status_e;

  typedef enum logic [1:0] {
    LS_INVALID  = 2'd0,
    LS_VALID    = 2'd1,
    LS_MODIFIED = 2'd2,
    LS_RESERVED = 2'd3
  } line_state_e;

  typedef enum logic [1:0] {
    MQ_READ      = 2'd0,
    MQ_WRITE     = 2'd1,
    MQ_WRITEBACK = 2'd2
  } mq_type_e;

  // lookup results handed from datapath to control
  typedef struct packed {
    logic hit;
    logic victimAvail;
    logic victimDirty;
    logic mshrHit;
    logic mshrCanMerge;
    logic mshrFree;
  } probe_t;

  // action strobes handed from control to datapath and queue
  typedef struct packed {
    logic touchLru;
    logic markModified;
    logic markInvalid;
    logic reserveVictim;
    logic mshrAlloc;
    logic mshrMerge;
    logic pushWrite;
    logic pushRead;
    logic pushWb;
  } strobe_t;

endpackage

// File: rtl/gpu_l1d_decide.sv
module gpu_l1d_decide
  import l1d_pkg::*;
(
  input  logic    reqValid,
  input  logic    reqWrite,
  input  logic    reqAtomic,
  input  logic    reqLocal,
  input  logic    fillValid,
  input  probe_t  probe,
  input  logic    mqFree1,
  input  logic    mqFree2,
  output strobe_t strb,
  output status_e status
);

  always_comb begin
    strb   = '0;
    status = ST_HIT;
    if (reqValid) begin
      if (fillValid) begin
        // fill owns the arrays this cycle
        status = ST_RESFAIL;
      end else if (reqWrite) begin
        if (probe.hit) begin
          if (reqLocal) begin
            strb.touchLru     = 1'b1;
            strb.markModified = 1'b1;
          end else if (mqFree1) begin
            strb.pushWrite   = 1'b1;
            strb.markInvalid = 1'b1;
          end else begin
            status = ST_RESFAIL;
          end
        end else if (mqFree1) begin
          strb.pushWrite = 1'b1;
          status         = ST_MISS;
        end else begin
          status = ST_RESFAIL;
        end
      end else begin
        if (probe.hit) begin
          strb.touchLru = 1'b1;
          if (reqAtomic && !reqLocal) strb.markModified = 1'b1;
        end else if (!mqFree2) begin
          status = ST_RESFAIL;
        end else if (probe.mshrHit) begin
          if (probe.mshrCanMerge) begin
            strb.mshrMerge = 1'b1;
            status         = ST_MISS;
          end else begin
            status = ST_RESFAIL;
          end
        end else if (probe.mshrFree && probe.victimAvail) begin
          strb.mshrAlloc     = 1'b1;
          strb.reserveVictim = 1'b1;
          strb.pushRead      = 1'b1;
          strb.pushWb        = probe.victimDirty;
          status             = ST_MISS;
        end else begin
          status = ST_RESFAIL;
        end
      end
    end
  end

endmodule

// File: rtl/gpu_l1d_tags.sv
module gpu_l1d_tags
  import l1d_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int LINE_BYTES     = 128,
  parameter int NUM_SETS       = 16,
  parameter int NUM_WAYS       = 4,
  parameter int MSHR_ENTRIES   = 4,
  parameter int MSHR_MAX_MERGE = 4,
  localparam int BA_W          = ADDR_W - $clog2(LINE_BYTES)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [BA_W-1:0] reqBlockAddr,
  input  logic            fillValid,
  input  logic [BA_W-1:0] fillBlockAddr,
  input  strobe_t         strb,
  output probe_t          probe,
  output logic [BA_W-1:0] victimBlockAddr
);

  localparam int SET_W = $clog2(NUM_SETS);
  localparam int TAG_W = BA_W - SET_W;
  localparam int WAY_W = $clog2(NUM_WAYS);
  localparam int MSH_W = $clog2(MSHR_ENTRIES);
  localparam int CNT_W = $clog2(MSHR_MAX_MERGE + 1);

  typedef logic [NUM_WAYS-1:0][WAY_W-1:0] age_row_t;

  line_state_e          stateArr [NUM_SETS][NUM_WAYS];
  logic [TAG_W-1:0]     tagArr   [NUM_SETS][NUM_WAYS];
  age_row_t             ageArr   [NUM_SETS];
  age_row_t             ageNext  [NUM_SETS];

  logic                 mValid [MSHR_ENTRIES];
  logic [BA_W-1:0]      mBa    [MSHR_ENTRIES];
  logic [WAY_W-1:0]     mWay   [MSHR_ENTRIES];
  logic [CNT_W-1:0]     mCnt   [MSHR_ENTRIES];

  logic [SET_W-1:0] reqSet, fillSet;
  logic [TAG_W-1:0] reqTag;
  assign reqSet  = reqBlockAddr[SET_W-1:0];
  assign reqTag  = reqBlockAddr[BA_W-1:SET_W];
  assign fillSet = fillBlockAddr[SET_W-1:0];

  logic unusedStrb;
  assign unusedStrb = strb.pushWrite ^ strb.pushRead ^ strb.pushWb;

  // ---------------- tag lookup and victim choice ----------------
  logic             hitFound, invFound, oldFound;
  logic [WAY_W-1:0] hitWay, invWay, oldWay, victimWay;
  logic [WAY_W-1:0] oldAge;

  always_comb begin
    hitFound = 1'b0; hitWay = '0;
    invFound = 1'b0; invWay = '0;
    oldFound = 1'b0; oldWay = '0; oldAge = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if ((stateArr[reqSet][w] == LS_VALID || stateArr[reqSet][w] == LS_MODIFIED)
          && tagArr[reqSet][w] == reqTag && !hitFound) begin
        hitFound = 1'b1;
        hitWay   = WAY_W'(w);
      end
      if (stateArr[reqSet][w] == LS_INVALID && !invFound) begin
        invFound = 1'b1;
        invWay   = WAY_W'(w);
      end
      if ((stateArr[reqSet][w] == LS_VALID || stateArr[reqSet][w] == LS_MODIFIED)
          && (!oldFound || ageArr[reqSet][w] > oldAge)) begin
        oldFound = 1'b1;
        oldWay   = WAY_W'(w);
        oldAge   = ageArr[reqSet][w];
      end
    end
  end

  assign victimWay         = invFound ? invWay : oldWay;
  assign probe.hit         = hitFound;
  assign probe.victimAvail = invFound || oldFound;
  assign probe.victimDirty = !invFound && oldFound && (stateArr[reqSet][oldWay] == LS_MODIFIED);
  assign victimBlockAddr   = {tagArr[reqSet][victimWay], reqSet};

  // ---------------- pending-miss table lookup ----------------
  logic             mHit, mFreeFound, fHit;
  logic [MSH_W-1:0] mHitIdx, mFreeIdx, fIdx;

  always_comb begin
    mHit = 1'b0; mHitIdx = '0;
    mFreeFound = 1'b0; mFreeIdx = '0;
    fHit = 1'b0; fIdx = '0;
    for (int e = 0; e < MSHR_ENTRIES; e++) begin
      if (mValid[e] && mBa[e] == reqBlockAddr && !mHit) begin
        mHit    = 1'b1;
        mHitIdx = MSH_W'(e);
      end
      if (!mValid[e] && !mFreeFound) begin
        mFreeFound = 1'b1;
        mFreeIdx   = MSH_W'(e);
      end
      if (mValid[e] && mBa[e] == fillBlockAddr && !fHit) begin
        fHit = 1'b1;
        fIdx = MSH_W'(e);
      end
    end
  end

  assign probe.mshrHit      = mHit;
  assign probe.mshrCanMerge = mCnt[mHitIdx] < CNT_W'(MSHR_MAX_MERGE);
  assign probe.mshrFree     = mFreeFound;

  logic fillDone;
  assign fillDone = fillValid && fHit;

  // ---------------- true LRU ages ----------------
  function automatic age_row_t touchRow(age_row_t row, logic [WAY_W-1:0] way);
    age_row_t r;
    r = row;
    for (int v = 0; v < NUM_WAYS; v++) begin
      if (row[v] < row[way]) r[v] = row[v] + 1'b1;
    end
    r[way] = '0;
    return r;
  endfunction

  always_comb begin
    ageNext = ageArr;
    if (strb.touchLru) ageNext[reqSet] = touchRow(ageNext[reqSet], hitWay);
    if (fillDone)      ageNext[fillSet] = touchRow(ageNext[fillSet], mWay[fIdx]);
  end

  // ---------------- state update ----------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        for (int w = 0; w < NUM_WAYS; w++) begin
          stateArr[s][w]  <= LS_INVALID;
          tagArr[s][w]    <= '0;
          ageArr[s][w]    <= WAY_W'(w);
        end
      end
      for (int e = 0; e < MSHR_ENTRIES; e++) begin
        mValid[e] <= 1'b0;
        mBa[e]    <= '0;
        mWay[e]   <= '0;
        mCnt[e]   <= '0;
      end
    end else begin
      ageArr <= ageNext;
      if (strb.markModified) stateArr[reqSet][hitWay] <= LS_MODIFIED;
      if (strb.markInvalid)  stateArr[reqSet][hitWay] <= LS_INVALID;
      if (strb.reserveVictim) begin
        stateArr[reqSet][victimWay] <= LS_RESERVED;
        tagArr[reqSet][victimWay]   <= reqTag;
      end
      if (fillDone) stateArr[fillSet][mWay[fIdx]] <= LS_VALID;
      if (strb.mshrAlloc) begin
        mValid[mFreeIdx] <= 1'b1;
        mBa[mFreeIdx]    <= reqBlockAddr;
        mWay[mFreeIdx]   <= victimWay;
        mCnt[mFreeIdx]   <= CNT_W'(1);
      end
      if (strb.mshrMerge) mCnt[mHitIdx] <= mCnt[mHitIdx] + 1'b1;
      if (fillDone) mValid[fIdx] <= 1'b0;
    end
  end

endmodule

// File: rtl/gpu_l1d_missq.sv
module gpu_l1d_missq #(
  parameter int  DEPTH = 4,
  parameter int  BA_W  = 25,
  parameter int  SZ_W  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push0Valid,
  input  logic [1:0]       push0Type,
  input  logic [BA_W-1:0]  push0Ba,
  input  logic [SZ_W-1:0]  push0Size,
  input  logic             push1Valid,
  input  logic [1:0]       push1Type,
  input  logic [BA_W-1:0]  push1Ba,
  input  logic [SZ_W-1:0]  push1Size,
  output logic             outValid,
  input  logic             outReady,
  output logic [1:0]       outType,
  output logic [BA_W-1:0]  outBa,
  output logic [SZ_W-1:0]  outSize,
  output logic [CNT_W-1:0] count,
  output logic             free1,
  output logic             free2
);

  // DEPTH is a power of two so the pointers wrap on their own
  localparam int PTR_W = $clog2(DEPTH);

  logic [1:0]      typeMem [DEPTH];
  logic [BA_W-1:0] baMem   [DEPTH];
  logic [SZ_W-1:0] sizeMem [DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr, wrPtr1;
  logic pop;

  assign pop      = outValid && outReady;
  assign outValid = count != '0;
  assign outType  = typeMem[rdPtr];
  assign outBa    = baMem[rdPtr];
  assign outSize  = sizeMem[rdPtr];
  assign free1    = count <= CNT_W'(DEPTH - 1);
  assign free2    = count <= CNT_W'(DEPTH - 2);
  assign wrPtr1   = push0Valid ? wrPtr + 1'b1 : wrPtr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        typeMem[i] <= '0;
        baMem[i]   <= '0;
        sizeMem[i] <= '0;
      end
    end else begin
      if (push0Valid) begin
        typeMem[wrPtr] <= push0Type;
        baMem[wrPtr]   <= push0Ba;
        sizeMem[wrPtr] <= push0Size;
      end
      if (push1Valid) begin
        typeMem[wrPtr1] <= push1Type;
        baMem[wrPtr1]   <= push1Ba;
        sizeMem[wrPtr1] <= push1Size;
      end
      wrPtr <= wrPtr + PTR_W'(push0Valid) + PTR_W'(push1Valid);
      rdPtr <= rdPtr + PTR_W'(pop);
      count <= count + CNT_W'(push0Valid) + CNT_W'(push1Valid) - CNT_W'(pop);
    end
  end

endmodule

// File: rtl/gpu_l1d_ctrl.sv
module gpu_l1d_ctrl
  import l1d_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int LINE_BYTES     = 128,
  parameter int NUM_SETS       = 16,
  parameter int NUM_WAYS       = 4,
  parameter int MQ_DEPTH       = 4,
  parameter int MSHR_ENTRIES   = 4,
  parameter int MSHR_MAX_MERGE = 4
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 reqValid,
  input  logic [ADDR_W-1:0]                    reqAddr,
  input  logic                                 reqWrite,
  input  logic                                 reqAtomic,
  input  logic                                 reqLocal,
  input  logic [$clog2(LINE_BYTES):0]          reqSize,
  output logic                                 respValid,
  output logic [1:0]                           respStatus,
  input  logic                                 fillValid,
  input  logic [ADDR_W-$clog2(LINE_BYTES)-1:0] fillBlockAddr,
  output logic                                 mqValid,
  input  logic                                 mqReady,
  output logic [1:0]                           mqType,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0] mqBlockAddr,
  output logic [$clog2(LINE_BYTES):0]          mqSize
);

  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int BA_W  = ADDR_W - OFF_W;
  localparam int SZ_W  = OFF_W + 1;
  localparam int CNT_W = $clog2(MQ_DEPTH + 1);

  probe_t          probe;
  strobe_t         strb;
  status_e         status;
  logic            mqFree1, mqFree2;
  logic [CNT_W-1:0] mqCount;
  logic [BA_W-1:0] reqBlockAddr, victimBlockAddr;

  logic unusedOffsetBits;
  assign unusedOffsetBits = ^reqAddr[OFF_W-1:0];
  assign reqBlockAddr     = reqAddr[ADDR_W-1:OFF_W];

  assign respValid  = reqValid;
  assign respStatus = status;

  gpu_l1d_decide decide_i (
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAtomic(reqAtomic),
    .reqLocal (reqLocal),
    .fillValid(fillValid),
    .probe    (probe),
    .mqFree1  (mqFree1),
    .mqFree2  (mqFree2),
    .strb     (strb),
    .status   (status)
  );

  gpu_l1d_tags #(
    .ADDR_W        (ADDR_W),
    .LINE_BYTES    (LINE_BYTES),
    .NUM_SETS      (NUM_SETS),
    .NUM_WAYS      (NUM_WAYS),
    .MSHR_ENTRIES  (MSHR_ENTRIES),
    .MSHR_MAX_MERGE(MSHR_MAX_MERGE)
  ) tags_i (
    .clk            (clk),
    .rstN           (rstN),
    .reqBlockAddr   (reqBlockAddr),
    .fillValid      (fillValid),
    .fillBlockAddr  (fillBlockAddr),
    .strb           (strb),
    .probe          (probe),
    .victimBlockAddr(victimBlockAddr)
  );

  gpu_l1d_missq #(
    .DEPTH(MQ_DEPTH),
    .BA_W (BA_W),
    .SZ_W (SZ_W)
  ) missq_i (
    .clk       (clk),
    .rstN      (rstN),
    .push0Valid(strb.pushWrite || strb.pushRead),
    .push0Type (strb.pushWrite ? MQ_WRITE : MQ_READ),
    .push0Ba   (reqBlockAddr),
    .push0Size (strb.pushWrite ? reqSize : SZ_W'(LINE_BYTES)),
    .push1Valid(strb.pushWb),
    .push1Type (MQ_WRITEBACK),
    .push1Ba   (victimBlockAddr),
    .push1Size (SZ_W'(LINE_BYTES)),
    .outValid  (mqValid),
    .outReady  (mqReady),
    .outType   (mqType),
    .outBa     (mqBlockAddr),
    .outSize   (mqSize),
    .count     (mqCount),
    .free1     (mqFree1),
    .free2     (mqFree2)
  );

endmodule

// File: rtl/gpu_l1d_ctrl_chk.sv
module gpu_l1d_ctrl_chk #(
  parameter int  MQ_DEPTH = 4,
  localparam int CNT_W    = $clog2(MQ_DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqWrite,
  input logic             reqLocal,
  input logic             fillValid,
  input logic [1:0]       respStatus,
  input logic             mqValid,
  input logic             mqReady,
  input logic [CNT_W-1:0] mqCount
);

  logic popNow;
  assign popNow = mqValid && mqReady;

  // R13: queue occupancy bounded by its depth
  p_no_overflow_r13: assert property (@(posedge clk) disable iff (!rstN)
    int'(mqCount) <= MQ_DEPTH);

  // R12: a fill cycle refuses the access
  p_fill_refuse_r12: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && fillValid) |-> (respStatus == 2'd2));

  // R3: a refused access never adds queue entries
  p_refuse_no_push_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && respStatus == 2'd2) |=> (mqCount <= $past(mqCount)));

  // R7: a local store hit sends nothing
  p_local_hit_silent_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && reqLocal && respStatus == 2'd0)
    |=> (int'(mqCount) == int'($past(mqCount)) - int'($past(popNow))));

  // R8: a store miss adds exactly one entry
  p_store_miss_push_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && respStatus == 2'd1)
    |=> (int'(mqCount) == int'($past(mqCount)) + 1 - int'($past(popNow))));

  // R1: status code is always one of the three legal values
  p_status_legal_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (respStatus != 2'd3));

endmodule

bind gpu_l1d_ctrl gpu_l1d_ctrl_chk #(.MQ_DEPTH(MQ_DEPTH)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqWrite  (reqWrite),
  .reqLocal  (reqLocal),
  .fillValid (fillValid),
  .respStatus(respStatus),
  .mqValid   (mqValid),
  .mqReady   (mqReady),
  .mqCount   (mqCount)
);

// File: tb/gpu_l1d_ctrl_tb_top.sv
module gpu_l1d_ctrl_tb_top;

  localparam int ADDR_W = 32;
  localparam int LINE   = 128;
  localparam int BA_W   = 25;
  localparam int SZ_W   = 8;
  localparam logic [1:0] HIT = 2'd0, MISS = 2'd1, RF = 2'd2;
  localparam logic [1:0] T_RD = 2'd0, T_WR = 2'd1, T_WB = 2'd2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqAtomic = 1'b0, reqLocal = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [SZ_W-1:0]   reqSize = '0;
  logic respValid;
  logic [1:0] respStatus;
  logic fillValid = 1'b0;
  logic [BA_W-1:0] fillBlockAddr = '0;
  logic mqValid, mqReady;
  logic [1:0] mqType;
  logic [BA_W-1:0] mqBlockAddr;
  logic [SZ_W-1:0] mqSize;

  always #5 clk = ~clk;

  gpu_l1d_ctrl #(
    .MQ_DEPTH(4), .MSHR_ENTRIES(2), .MSHR_MAX_MERGE(2)
  ) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqAtomic(reqAtomic), .reqLocal(reqLocal),
    .reqSize(reqSize), .respValid(respValid), .respStatus(respStatus),
    .fillValid(fillValid), .fillBlockAddr(fillBlockAddr),
    .mqValid(mqValid), .mqReady(mqReady), .mqType(mqType),
    .mqBlockAddr(mqBlockAddr), .mqSize(mqSize)
  );

  typedef struct packed {
    logic [1:0]      t;
    logic [BA_W-1:0] ba;
    logic [SZ_W-1:0] sz;
  } item_t;

  item_t expQ[$];
  string tagQ[$];
  int nRun = 0;
  int nFail = 0;
  logic readyDrv = 1'b1;
  assign mqReady = readyDrv;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [BA_W-1:0] blk(int tag, int set);
    return BA_W'((tag << 4) | (set & 15));
  endfunction

  task automatic expPush(logic [1:0] t, logic [BA_W-1:0] b, int sz, string req);
    item_t it;
    it.t = t; it.ba = b; it.sz = SZ_W'(sz);
    expQ.push_back(it);
    tagQ.push_back(req);
  endtask

  task automatic access(logic [BA_W-1:0] b, bit wr, bit at, bit loc, int sz,
                        logic [1:0] exp, string req, string what);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = {b, 7'h24}; reqWrite = wr; reqAtomic = at;
    reqLocal = loc; reqSize = SZ_W'(sz);
    #2;
    chk(respValid && respStatus == exp, req, what, respStatus, exp);
    @(posedge clk);
    #1 reqValid = 1'b0;
  endtask

  task automatic fill(logic [BA_W-1:0] b);
    @(negedge clk);
    fillValid = 1'b1; fillBlockAddr = b;
    @(posedge clk);
    #1 fillValid = 1'b0;
  endtask

  task automatic drain(string req);
    repeat (8) @(negedge clk);
    chk(expQ.size() == 0, req, "queue drained vs expected", expQ.size(), 0);
  endtask

  // monitor: compare each handshaked queue head with the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (rstN && mqValid && mqReady) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R13", "unexpected queue entry", {mqType, mqBlockAddr, mqSize}, 0);
        end else begin
          item_t e;
          string r;
          e = expQ.pop_front();
          r = tagQ.pop_front();
          chk(mqType == e.t && mqBlockAddr == e.ba && mqSize == e.sz, r, "queue head",
              {mqType, mqBlockAddr, mqSize}, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R13", "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #3;
    chk(mqValid == 1'b0, "R1", "queue empty after reset", mqValid, 0);

    // R1/R3: first load misses and sends a line fill
    expPush(T_RD, blk(1, 0), LINE, "R3");
    access(blk(1, 0), 0, 0, 0, 0, MISS, "R1", "first load misses");
    // R10: merge then limit
    access(blk(1, 0), 0, 0, 0, 0, MISS, "R10", "merge into pending entry");
    access(blk(1, 0), 0, 0, 0, 0, RF, "R10", "merge limit reached");
    // R12: fill with concurrent access is refused
    @(negedge clk);
    fillValid = 1'b1; fillBlockAddr = blk(1, 0);
    reqValid = 1'b1; reqAddr = {blk(2, 0), 7'h0}; reqWrite = 1'b0; reqLocal = 1'b0;
    #2;
    chk(respStatus == RF, "R12", "access during fill refused", respStatus, RF);
    @(posedge clk);
    #1 fillValid = 1'b0; reqValid = 1'b0;
    access(blk(1, 0), 0, 0, 0, 0, HIT, "R12", "filled line hits");
    access(blk(1, 0), 0, 0, 0, 0, HIT, "R2", "load hit");
    drain("R2");

    // R5/R4/R7: LRU chain in set 1
    for (int t = 1; t <= 4; t++) begin
      expPush(T_RD, blk(t, 1), LINE, "R5");
      access(blk(t, 1), 0, 0, 0, 0, MISS, "R5", "fill ways of set 1");
      fill(blk(t, 1));
    end
    access(blk(1, 1), 0, 0, 0, 0, HIT, "R2", "touch oldest line");
    drain("R5");
    access(blk(3, 1), 1, 0, 1, 4, HIT, "R7", "local store hit");
    @(negedge clk);
    #3;
    chk(mqValid == 1'b0, "R7", "local store hit sends nothing", mqValid, 0);
    expPush(T_RD, blk(5, 1), LINE, "R5");
    access(blk(5, 1), 0, 0, 0, 0, MISS, "R5", "evict LRU clean line t2");
    fill(blk(5, 1));
    expPush(T_RD, blk(6, 1), LINE, "R5");
    access(blk(6, 1), 0, 0, 0, 0, MISS, "R5", "evict LRU clean line t4");
    fill(blk(6, 1));
    expPush(T_RD, blk(7, 1), LINE, "R5");
    access(blk(7, 1), 0, 0, 0, 0, MISS, "R5", "evict LRU clean line t1");
    fill(blk(7, 1));
    expPush(T_RD, blk(8, 1), LINE, "R4");
    expPush(T_WB, blk(3, 1), LINE, "R4");
    access(blk(8, 1), 0, 0, 0, 0, MISS, "R4", "evict dirty line t3");
    fill(blk(8, 1));
    access(blk(6, 1), 0, 0, 0, 0, HIT, "R5", "recently filled line kept");
    drain("R4");

    // R6: global store hit writes through and invalidates
    expPush(T_WR, blk(8, 1), 4, "R6");
    access(blk(8, 1), 1, 0, 0, 4, HIT, "R6", "global store hit");
    expPush(T_RD, blk(8, 1), LINE, "R6");
    access(blk(8, 1), 0, 0, 0, 0, MISS, "R6", "line invalidated");
    fill(blk(8, 1));
    drain("R6");

    // R8: store miss, no allocation
    expPush(T_WR, blk(9, 2), 8, "R8");
    access(blk(9, 2), 1, 0, 0, 8, MISS, "R8", "store miss");
    expPush(T_RD, blk(9, 2), LINE, "R8");
    access(blk(9, 2), 0, 0, 0, 0, MISS, "R8", "store miss did not allocate");
    fill(blk(9, 2));

    // R9: atomic marks dirty, eviction writes back
    access(blk(9, 2), 0, 1, 0, 0, HIT, "R9", "atomic load hit");
    for (int t = 10; t <= 12; t++) begin
      expPush(T_RD, blk(t, 2), LINE, "R9");
      access(blk(t, 2), 0, 0, 0, 0, MISS, "R9", "fill set 2");
      fill(blk(t, 2));
    end
    expPush(T_RD, blk(13, 2), LINE, "R9");
    expPush(T_WB, blk(9, 2), LINE, "R9");
    access(blk(13, 2), 0, 0, 0, 0, MISS, "R9", "evict atomically dirtied line");
    fill(blk(13, 2));
    drain("R9");

    // R3/R6/R8: queue backpressure
    @(negedge clk);
    readyDrv = 1'b0;
    for (int t = 1; t <= 3; t++) begin
      expPush(T_WR, blk(t, 5), 4 * t, "R13");
      access(blk(t, 5), 1, 0, 0, 4 * t, MISS, "R8", "store miss queued");
    end
    access(blk(1, 6), 0, 0, 0, 0, RF, "R3", "load miss needs two slots");
    expPush(T_WR, blk(4, 5), 32, "R13");
    access(blk(4, 5), 1, 0, 0, 32, MISS, "R8", "store miss takes last slot");
    access(blk(5, 5), 1, 0, 0, 16, RF, "R8", "store miss with full queue");
    access(blk(13, 2), 1, 0, 0, 4, RF, "R6", "global store hit with full queue");
    @(negedge clk);
    readyDrv = 1'b1;
    drain("R13");
    access(blk(13, 2), 0, 0, 0, 0, HIT, "R6", "refused store left line valid");
    access(blk(1, 6), 0, 0, 0, 0, MISS, "R3", "refused load left no pending entry");
    expPush(T_RD, blk(1, 6), LINE, "R3");
    fill(blk(1, 6));

    // R11: pending table exhaustion
    expPush(T_RD, blk(1, 7), LINE, "R11");
    access(blk(1, 7), 0, 0, 0, 0, MISS, "R11", "first pending entry");
    expPush(T_RD, blk(1, 8), LINE, "R11");
    access(blk(1, 8), 0, 0, 0, 0, MISS, "R11", "second pending entry");
    access(blk(1, 9), 0, 0, 0, 0, RF, "R11", "no free pending entry");
    fill(blk(1, 7));
    expPush(T_RD, blk(1, 9), LINE, "R11");
    access(blk(1, 9), 0, 0, 0, 0, MISS, "R11", "entry freed by fill");
    fill(blk(1, 8));
    fill(blk(1, 9));
    access(blk(1, 9), 0, 0, 0, 0, HIT, "R12", "fill completes miss");
    drain("R11");

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule